// File: doc/BRIEF.md
# Baud Rate and Character Frame Timer

This block is the per-channel timing engine of a serial controller. A down-counter reloads from a 16-bit time constant and rolls over once every time-constant-plus-two ticks of a chosen reference. Each rollover is a zero-count event. A prescaler stretches these events into transmit and receive bit-clock enables. Each bit lasts twice the counter period times a selectable multiplier of 1, 16, 32 or 64.

The block also decodes the character format into a frame length. The format is the data bits, one start bit, an optional parity bit and the stop bits. The length is kept in half-bit units so that one and a half stop bits stays an integer count. For each direction, a frame counter steps on half-bit boundaries and emits a one-cycle character-done strobe at the end of every frame. Loopback shortens the frame to one bit time.

The reference is one of two tick enables. One comes from a crystal-derived clock and the other from the system clock. All outputs are single-cycle pulses that are registered in the clock domain of the block.

Top module: `baud_frame_timer`

## Requirements
- R1: With the generator running and ticks on every cycle, zero-count events come every `timeConst + 2` ticks. The first one is seen `timeConst + 3` cycles after the cycle in which a configuration change is applied.
- R2: While `runEn` is low, no zero pulse, bit enable or character-done strobe is produced.
- R3: `srcSel` = 1 counts `sysTick` and `srcSel` = 0 counts `xtalTick`. The tick that is not selected has no effect on any interval.
- R4: `multSel` codes 0, 1, 2 and 3 give multipliers 1, 16, 32 and 64. A bit enable is produced every `2 × multiplier × (timeConst + 2)` ticks.
- R5: `txBitEn` and `txCharDone` are produced only when `txClkSel` = 2. `rxBitEn` and `rxCharDone` are produced only when `rxClkSel` = 2. Any other code gives no pulses on that direction.
- R6: `frameHalf` = 2 × (data + 1 + parity) + stop half-bits. `dataSel` codes 0, 1, 2 and 3 give 5, 7, 6 and 8 data bits. `stopSel` codes 0, 1, 2 and 3 give 0, 2, 3 and 4 stop half-bits. `parityEn` adds one bit.
- R7: With `loopback` high, `frameHalf` is 2 whatever the other format fields are.
- R8: A character-done strobe is produced every `frameHalf × multiplier × (timeConst + 2)` ticks. This holds for odd frame lengths too.
- R9: `zeroPulse` is produced only while `extIntEn` is high. `extIntEn` has no effect on the bit enables or on character done.
- R10: A change to any timing or format input reloads the counter, the prescaler and both frame counters. This happens at once, even in mid-period.
- R11: During and right after reset, every pulse output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timeConst | input | 16 | Counter time constant |
| runEn | input | 1 | Generator run enable |
| srcSel | input | 1 | 1: system tick, 0: crystal tick |
| xtalTick | input | 1 | Crystal reference tick enable |
| sysTick | input | 1 | System reference tick enable |
| multSel | input | 2 | Clock multiplier code |
| txClkSel | input | 2 | Transmit bit-clock source, 2 = this generator |
| rxClkSel | input | 2 | Receive bit-clock source, 2 = this generator |
| dataSel | input | 2 | Data-bit count code |
| stopSel | input | 2 | Stop-bit code |
| parityEn | input | 1 | Adds a parity bit to the frame |
| loopback | input | 1 | Frame shortened to one bit time |
| extIntEn | input | 1 | Gates the zero-count pulse |
| zeroPulse | output | 1 | Counter reached zero |
| txBitEn | output | 1 | Transmit bit-clock enable |
| rxBitEn | output | 1 | Receive bit-clock enable |
| txCharDone | output | 1 | Transmit frame complete |
| rxCharDone | output | 1 | Receive frame complete |
| frameHalf | output | 5 | Frame length in half bits |

## Verification
The bit enable and the character-done strobe can fire in the same cycle. When the frame length is an even number of half bits, every frame end lands on a bit boundary. With one and a half stop bits, the frame end alternates between a bit boundary and mid-bit. The bench sweeps every data, stop and parity code at the shortest counter period. For each case it computes the first position and the spacing of both strobes arithmetically. A frame end that comes one half-bit early or late, or that waits for the next whole bit, moves the measured position and is caught.

// File: rtl/bft_pkg.sv
package bft_pkg;
  parameter int FRAME_W = 5;
  localparam logic [1:0] BRG_SEL = 2'd2;

  typedef struct packed {
    logic reload;
    logic advance;
  } ctlStrobe_t;

  typedef struct packed {
    logic zeroEv;
    logic halfEv;
    logic bitEv;
  } evt_t;
endpackage

// File: rtl/bft_datapath.sv
module bft_datapath
  import bft_pkg::*;
#(
  parameter int TC_W     = 16,
  parameter int MAX_MULT = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ctlStrobe_t      strobe,
  input  logic [TC_W-1:0] timeConst,
  input  logic [1:0]      multSel,
  output evt_t            evt
);
  localparam int CNT_W = TC_W + 1;
  localparam int PRE_W = $clog2(2 * MAX_MULT);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] periodM1;
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] multVal;
  logic [PRE_W-1:0] halfMask;
  logic [PRE_W-1:0] preTop;
  logic [PRE_W:0]   dblM1;
  logic             zeroAt;

  // period is timeConst + 2 ticks, so the reload value is timeConst + 1
  assign periodM1 = {1'b0, timeConst} + CNT_W'(1);

  always_comb begin
    case (multSel)
      2'd0:    multVal = PRE_W'(1);
      2'd1:    multVal = PRE_W'(16);
      2'd2:    multVal = PRE_W'(32);
      default: multVal = PRE_W'(64);
    endcase
  end

  assign halfMask = multVal - PRE_W'(1);
  assign dblM1    = {multVal, 1'b0} - (PRE_W+1)'(1);
  assign preTop   = dblM1[PRE_W-1:0];

  assign zeroAt     = strobe.advance && !strobe.reload && (cnt == '0);
  assign evt.zeroEv = zeroAt;
  assign evt.halfEv = zeroAt && ((pre & halfMask) == halfMask);
  assign evt.bitEv  = zeroAt && (pre == preTop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      pre <= '0;
    end else if (strobe.reload) begin
      cnt <= periodM1;
      pre <= '0;
    end else if (strobe.advance) begin
      if (cnt == '0) begin
        cnt <= periodM1;
        pre <= (pre == preTop) ? '0 : pre + PRE_W'(1);
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.reload |-> cnt <= periodM1);

  p_bit_on_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt.bitEv |-> evt.halfEv);

  p_pre_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.reload |-> pre <= preTop);
endmodule

// File: rtl/bft_control.sv
module bft_control
  import bft_pkg::*;
#(
  parameter int TC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TC_W-1:0]    timeConst,
  input  logic               runEn,
  input  logic               srcSel,
  input  logic               xtalTick,
  input  logic               sysTick,
  input  logic [1:0]         multSel,
  input  logic [1:0]         txClkSel,
  input  logic [1:0]         rxClkSel,
  input  logic [1:0]         dataSel,
  input  logic [1:0]         stopSel,
  input  logic               parityEn,
  input  logic               loopback,
  input  logic               extIntEn,
  input  evt_t               evt,
  output ctlStrobe_t         strobe,
  output logic               txActive,
  output logic               rxActive,
  output logic [FRAME_W-1:0] frameHalf,
  output logic               zeroPulse,
  output logic               txBitEn,
  output logic               rxBitEn
);
  localparam int CFG_W = TC_W + 14;

  logic [CFG_W-1:0]   cfgNow;
  logic [CFG_W-1:0]   cfgPrev;
  logic               primed;
  logic               cfgChanged;
  logic [FRAME_W-1:0] dataBits;
  logic [FRAME_W-1:0] stopHalf;
  logic [FRAME_W-1:0] bitsNoStop;

  // every input that shapes timing or framing takes part in change detection
  assign cfgNow = {timeConst, runEn, srcSel, multSel, txClkSel, rxClkSel,
                   dataSel, stopSel, parityEn, loopback};
  assign cfgChanged = (cfgNow != cfgPrev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgPrev <= '0;
      primed  <= 1'b0;
    end else begin
      cfgPrev <= cfgNow;
      primed  <= 1'b1;
    end
  end

  assign strobe.reload  = !runEn || cfgChanged || !primed;
  assign strobe.advance = runEn && (srcSel ? sysTick : xtalTick);

  assign txActive = (txClkSel == BRG_SEL);
  assign rxActive = (rxClkSel == BRG_SEL);

  always_comb begin
    case (dataSel)
      2'd0:    dataBits = FRAME_W'(5);
      2'd1:    dataBits = FRAME_W'(7);
      2'd2:    dataBits = FRAME_W'(6);
      default: dataBits = FRAME_W'(8);
    endcase
    case (stopSel)
      2'd0:    stopHalf = FRAME_W'(0);
      2'd1:    stopHalf = FRAME_W'(2);
      2'd2:    stopHalf = FRAME_W'(3);
      default: stopHalf = FRAME_W'(4);
    endcase
  end

  assign bitsNoStop = dataBits + FRAME_W'(1) + FRAME_W'(parityEn);
  assign frameHalf  = loopback ? FRAME_W'(2) : ((bitsNoStop << 1) + stopHalf);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zeroPulse <= 1'b0;
      txBitEn   <= 1'b0;
      rxBitEn   <= 1'b0;
    end else begin
      zeroPulse <= evt.zeroEv && extIntEn;
      txBitEn   <= evt.bitEv && txActive;
      rxBitEn   <= evt.bitEv && rxActive;
    end
  end

  p_zero_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    zeroPulse |-> $past(extIntEn));

  p_tx_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    txBitEn |-> $past(txClkSel) == BRG_SEL);

  p_rx_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rxBitEn |-> $past(rxClkSel) == BRG_SEL);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !runEn |=> !zeroPulse && !txBitEn && !rxBitEn);

  p_frame_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frameHalf >= FRAME_W'(2) && frameHalf <= FRAME_W'(24));
endmodule

// File: rtl/bft_frame_counter.sv
module bft_frame_counter
  import bft_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               enable,
  input  logic               halfEv,
  input  logic [FRAME_W-1:0] frameLen,
  output logic               charDone
);
  logic [FRAME_W-1:0] halfCount;
  logic               lastHalf;

  assign lastHalf = (halfCount == (frameLen - FRAME_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halfCount <= '0;
      charDone  <= 1'b0;
    end else if (clr) begin
      halfCount <= '0;
      charDone  <= 1'b0;
    end else begin
      charDone <= enable && halfEv && lastHalf;
      if (enable && halfEv)
        halfCount <= lastHalf ? '0 : halfCount + FRAME_W'(1);
    end
  end

  p_half_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> halfCount < frameLen);

  p_done_on_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
    charDone |-> $past(halfEv) && $past(enable));
endmodule

// File: rtl/baud_frame_timer.sv
module baud_frame_timer
  import bft_pkg::*;
#(
  parameter int TC_W     = 16,
  parameter int MAX_MULT = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TC_W-1:0]    timeConst,
  input  logic               runEn,
  input  logic               srcSel,
  input  logic               xtalTick,
  input  logic               sysTick,
  input  logic [1:0]         multSel,
  input  logic [1:0]         txClkSel,
  input  logic [1:0]         rxClkSel,
  input  logic [1:0]         dataSel,
  input  logic [1:0]         stopSel,
  input  logic               parityEn,
  input  logic               loopback,
  input  logic               extIntEn,
  output logic               zeroPulse,
  output logic               txBitEn,
  output logic               rxBitEn,
  output logic               txCharDone,
  output logic               rxCharDone,
  output logic [FRAME_W-1:0] frameHalf
);
  ctlStrobe_t strobe;
  evt_t       evt;
  logic [1:0] dirActive;
  logic [1:0] dirDone;

  bft_control #(.TC_W(TC_W)) u_control (
    .clk(clk), .rst_n(rst_n), .timeConst(timeConst), .runEn(runEn),
    .srcSel(srcSel), .xtalTick(xtalTick), .sysTick(sysTick),
    .multSel(multSel), .txClkSel(txClkSel), .rxClkSel(rxClkSel),
    .dataSel(dataSel), .stopSel(stopSel), .parityEn(parityEn),
    .loopback(loopback), .extIntEn(extIntEn), .evt(evt),
    .strobe(strobe), .txActive(dirActive[0]), .rxActive(dirActive[1]),
    .frameHalf(frameHalf), .zeroPulse(zeroPulse),
    .txBitEn(txBitEn), .rxBitEn(rxBitEn)
  );

  bft_datapath #(.TC_W(TC_W), .MAX_MULT(MAX_MULT)) u_datapath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .timeConst(timeConst), .multSel(multSel), .evt(evt)
  );

  for (genvar d = 0; d < 2; d++) begin : g_dir
    bft_frame_counter u_frame (
      .clk(clk), .rst_n(rst_n), .clr(strobe.reload),
      .enable(dirActive[d]), .halfEv(evt.halfEv),
      .frameLen(frameHalf), .charDone(dirDone[d])
    );
  end

  assign txCharDone = dirDone[0];
  assign rxCharDone = dirDone[1];
endmodule

// File: tb/baud_frame_timer_bench.sv
module baud_frame_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] timeConst = '0;
  logic        runEn = 1'b0, srcSel = 1'b0, xtalTick = 1'b0, sysTick = 1'b0;
  logic [1:0]  multSel = '0, txClkSel = '0, rxClkSel = '0, dataSel = '0, stopSel = '0;
  logic        parityEn = 1'b0, loopback = 1'b0, extIntEn = 1'b0;
  logic        zeroPulse, txBitEn, rxBitEn, txCharDone, rxCharDone;
  logic [4:0]  frameHalf;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  baud_frame_timer u_baud_frame_timer (
    .clk(clk), .rst_n(rst_n), .timeConst(timeConst), .runEn(runEn),
    .srcSel(srcSel), .xtalTick(xtalTick), .sysTick(sysTick),
    .multSel(multSel), .txClkSel(txClkSel), .rxClkSel(rxClkSel),
    .dataSel(dataSel), .stopSel(stopSel), .parityEn(parityEn),
    .loopback(loopback), .extIntEn(extIntEn), .zeroPulse(zeroPulse),
    .txBitEn(txBitEn), .rxBitEn(rxBitEn), .txCharDone(txCharDone),
    .rxCharDone(rxCharDone), .frameHalf(frameHalf)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int multOf(input int sel);
    case (sel)
      0: return 1;
      1: return 16;
      2: return 32;
      default: return 64;
    endcase
  endfunction

  function automatic int halfOf(input int d, input int s, input int p, input int lb);
    int bits, st;
    if (lb != 0) return 2;
    case (d) 0: bits = 5; 1: bits = 7; 2: bits = 6; default: bits = 8; endcase
    case (s) 0: st = 0; 1: st = 2; 2: st = 3; default: st = 4; endcase
    return 2 * (bits + 1 + p) + st;
  endfunction

  // checks spacing and (for one tick per cycle) the first position of one output
  task automatic judge(input string req, input string name, input bit expOn,
                       input int cnt, input int first, input int second,
                       input int interval, input int firstPos, input bit checkFirst);
    if (!expOn) begin
      check(cnt == 0, req, {name, " silent"}, cnt, 0);
    end else begin
      check(cnt >= 2, req, {name, " count"}, cnt, 2);
      check(second - first == interval, req, {name, " spacing"}, second - first, interval);
      if (checkFirst)
        check(first == firstPos, req, {name, " first"}, first, firstPos);
    end
  endtask

  task automatic runCase(input int tc, input int src, input int div, input int ms,
                         input int txs, input int rxs, input int d, input int s,
                         input int p, input int lb, input int ext, input int run,
                         input bit skipIdle);
    int period, m, fh, n;
    int cnt[5], first[5], second[5];
    logic [4:0] outs;
    if (!skipIdle) begin
      runEn = 1'b0;
      repeat (2) begin @(posedge clk); @(negedge clk); end
    end
    timeConst = 16'(tc); srcSel = src[0]; multSel = 2'(ms);
    txClkSel = 2'(txs); rxClkSel = 2'(rxs); dataSel = 2'(d); stopSel = 2'(s);
    parityEn = p[0]; loopback = lb[0]; extIntEn = ext[0]; runEn = run[0];
    period = tc + 2; m = multOf(ms); fh = halfOf(d, s, p, lb);
    n = 2 * fh * m * period * div + 2 * period * div + 10;
    for (int i = 0; i < 5; i++) begin cnt[i] = 0; first[i] = 0; second[i] = 0; end
    for (int cyc = 1; cyc <= n; cyc++) begin
      // selected source ticks every div cycles, the other ticks every cycle
      if (src != 0) begin sysTick = ((cyc % div) == 0); xtalTick = 1'b1; end
      else begin xtalTick = ((cyc % div) == 0); sysTick = 1'b1; end
      @(posedge clk); @(negedge clk);
      outs = {rxCharDone, txCharDone, rxBitEn, txBitEn, zeroPulse};
      for (int i = 0; i < 5; i++) if (outs[i]) begin
        cnt[i]++;
        if (cnt[i] == 1) first[i] = cyc;
        if (cnt[i] == 2) second[i] = cyc;
      end
    end
    check(frameHalf == 5'(fh), (lb != 0) ? "R7" : "R6", "frameHalf", frameHalf, fh);
    // R1 R3 R9 zero pulse; R4 R5 bit enables; R8 R5 frame done; R10 first positions
    judge((run == 0) ? "R2" : (ext == 0) ? "R9" : (div > 1) ? "R3" : "R1", "zeroPulse",
          run != 0 && ext != 0, cnt[0], first[0], second[0],
          period * div, period + 1, div == 1);
    judge((run == 0) ? "R2" : (txs != 2) ? "R5" : "R4", "txBitEn",
          run != 0 && txs == 2, cnt[1], first[1], second[1],
          2 * m * period * div, 2 * m * period + 1, div == 1);
    judge((run == 0) ? "R2" : (rxs != 2) ? "R5" : "R4", "rxBitEn",
          run != 0 && rxs == 2, cnt[2], first[2], second[2],
          2 * m * period * div, 2 * m * period + 1, div == 1);
    judge((run == 0) ? "R2" : (txs != 2) ? "R5" : skipIdle ? "R10" : "R8", "txCharDone",
          run != 0 && txs == 2, cnt[3], first[3], second[3],
          fh * m * period * div, fh * m * period + 1, div == 1);
    judge((run == 0) ? "R2" : (rxs != 2) ? "R5" : "R8", "rxCharDone",
          run != 0 && rxs == 2, cnt[4], first[4], second[4],
          fh * m * period * div, fh * m * period + 1, div == 1);
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish();
    end
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    check({zeroPulse, txBitEn, rxBitEn, txCharDone, rxCharDone} == 5'b0, "R11",
          "outputs in reset", int'({zeroPulse, txBitEn, rxBitEn, txCharDone, rxCharDone}), 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check({zeroPulse, txBitEn, rxBitEn, txCharDone, rxCharDone} == 5'b0, "R11",
          "outputs after reset", int'({zeroPulse, txBitEn, rxBitEn, txCharDone, rxCharDone}), 0);

    // R1 time constant sweep
    for (int tc = 0; tc < 6; tc++) runCase(tc, 0, 1, 0, 2, 2, 3, 1, 0, 0, 1, 1, 1'b0);
    // R6 R8 full frame-format sweep at the shortest period
    for (int d = 0; d < 4; d++)
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 2; p++) runCase(0, 0, 1, 0, 2, 2, d, s, p, 0, 1, 1, 1'b0);
    // R4 multiplier sweep
    for (int ms = 0; ms < 4; ms++) runCase(0, 0, 1, ms, 2, 2, 0, 1, 0, 0, 1, 1, 1'b0);
    // R3 source select with slower selected tick
    runCase(1, 1, 3, 0, 2, 2, 3, 1, 0, 0, 1, 1, 1'b0);
    runCase(1, 0, 4, 0, 2, 2, 3, 2, 1, 0, 1, 1, 1'b0);
    // R7 loopback
    runCase(2, 0, 1, 1, 2, 2, 3, 3, 1, 1, 1, 1, 1'b0);
    // R9 zero pulse masked, bit clocks still run
    runCase(1, 0, 1, 0, 2, 2, 1, 1, 0, 0, 0, 1, 1'b0);
    // R2 generator stopped
    runCase(1, 0, 1, 0, 2, 2, 1, 1, 0, 0, 1, 0, 1'b0);
    // R5 direction source codes
    runCase(0, 0, 1, 0, 0, 2, 0, 1, 0, 0, 1, 1, 1'b0);
    runCase(0, 0, 1, 0, 2, 1, 0, 1, 0, 0, 1, 1, 1'b0);
    runCase(0, 0, 1, 0, 3, 0, 0, 1, 0, 0, 1, 1, 1'b0);
    // R10 reload on change while running
    runCase(9, 0, 1, 0, 2, 2, 0, 2, 0, 0, 1, 1, 1'b0);
    runCase(2, 0, 1, 0, 2, 2, 0, 2, 0, 0, 1, 1, 1'b1);
    runCase(2, 0, 1, 0, 2, 2, 2, 1, 1, 0, 1, 1, 1'b1);
    finish();
  end
endmodule